// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block drives a four-bank, 32-bit-wide synchronous DRAM on behalf of one user port. Software-free and self-starting, it waits out the power-up interval after reset, closes every bank, issues the configured number of auto refreshes and programs the mode register. After that it accepts single-word read and write requests on a valid/ready interface and turns each into the shortest legal command stream. Each bank may hold one open row: a request that hits it goes straight to a column command, while a miss closes the old row and then opens the new one.

The device is programmed for single-word bursts, so every read or write command moves one word and no burst ever needs to be cut short. A free-running refresh timer raises a refresh request at a fixed interval. That request wins over any waiting user request: all open rows are closed together, and one auto refresh follows. Every minimum spacing between commands is a parameter counted in clocks. The bank-level spacings are held in per-bank down-counters, and the spacings that span the whole device are held in global ones. Read data is captured from the data bus a programmable CAS latency after the read command and returned in request order.

Top module: `sdram_sequencer`

## Requirements
- R1: After reset the bus carries NOP with CKE high for at least T_INIT cycles. The first command is then a precharge of all banks with A10 high, followed by exactly INIT_REFS auto refreshes and then a mode register set. No request is accepted before the mode register set.
- R2: The mode register set drives BA=00 and an address of A2:A0=000 (one-word burst), A3=0 (sequential), A6:A4=CAS latency and A9=1 (single-word writes). It is issued only with all banks closed, and at least T_MRD cycles pass before the next command.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as NOP 0111, ACT 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001 and MODE 0000. The request address is {bank[1:0], row, column}, and the bank field is driven on BA unchanged (00 selects the first bank, 11 the last).
- R4: The spacing from ACT to READ/WRITE on the same bank is at least T_RCD. From ACT to ACT it is at least T_RC on the same bank and at least T_RRD on any bank.
- R5: From PRECHARGE to ACT on the same bank at least T_RP passes. From ACT to PRECHARGE at least T_RAS passes, and from WRITE to PRECHARGE at least T_RDL.
- R6: A request to the open row of its bank is served with no ACT or PRECHARGE. A request to another row closes that bank with one single-bank PRECHARGE (A10 low) and then issues one ACT. READ and WRITE always drive A10 low.
- R7: Refresh is requested every REF_INTERVAL cycles and takes priority over pending user requests. Open banks are closed by one precharge-all, REFRESH is issued only with all banks closed, and the T_RC cycles that follow a REFRESH carry only NOP.
- R8: rsp_valid pulses for one cycle CAS_LAT+1 cycles after the READ command appears, carrying the bus data of the cycle CAS_LAT cycles after the READ. Responses return in order, and each holds the last data written to that address.
- R9: The data bus is driven only during a WRITE command, with that request's data. No WRITE is placed within CAS_LAT cycles after a READ.
- R10: DQM is all ones until the mode register set has been issued and all zeros afterwards, including every READ and WRITE.
- R11: req_ready is high only in the cycle whose next bus command is the READ or WRITE for the presented request, with matching bank and column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this clock edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2+ROW_W+COL_W | {bank, row, column} |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DATA_W | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | ROW_W | Row / column / mode address |
| sd_dqm | output | DATA_W/8 | Byte masks |
| sd_dq_out | output | DATA_W | Data toward the device |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | DATA_W | Data from the device |

## Verification
Directed cases right after a refresh separate three paths: a row hit (no ACT or PRECHARGE), a row miss (exactly one of each), and a read followed at once by a write to the same bank, which checks the bus turnaround. Random traffic over four banks, four rows and eight columns mixes hits, misses and bank interleaving with refreshes arriving mid-stream. A bus monitor measures every command spacing against its own copy of the timing rules, and a memory model behind the bus shows whether the data returned matches the data the bench wrote.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_POWER,
        PH_INIT_REF,
        PH_RUN
    } phase_e;

    // One-word bursts, sequential, given latency, single-word writes.
    function automatic logic [10:0] mode_word(input int unsigned cas_lat);
        logic [10:0] w;
        w      = '0;
        w[2:0] = 3'b000;
        w[3]   = 1'b0;
        w[6:4] = cas_lat[2:0];
        w[9]   = 1'b1;
        return w;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
    parameter int ROW_W = 12,
    parameter int T_RCD = 2,
    parameter int T_RAS = 5,
    parameter int T_RC  = 7,
    parameter int T_RP  = 2,
    parameter int T_RDL = 2,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_act,
    input  logic             ev_pre,
    input  logic             ev_col,
    input  logic             ev_wr,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             can_act,
    output logic             can_col,
    output logic             can_pre
);
    localparam logic [CW-1:0] RC_L  = CW'(T_RC - 1);
    localparam logic [CW-1:0] RCD_L = CW'(T_RCD - 1);
    localparam logic [CW-1:0] RAS_L = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RP_L  = CW'(T_RP - 1);
    localparam logic [CW-1:0] RDL_L = CW'(T_RDL - 1);

    logic [CW-1:0] act_cnt, col_cnt, pre_cnt;
    logic [CW-1:0] act_dec, col_dec, pre_dec;

    assign act_dec = (act_cnt != '0) ? act_cnt - 1'b1 : '0;
    assign col_dec = (col_cnt != '0) ? col_cnt - 1'b1 : '0;
    assign pre_dec = (pre_cnt != '0) ? pre_cnt - 1'b1 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open  <= 1'b0;
            open_row <= '0;
            act_cnt  <= '0;
            col_cnt  <= '0;
            pre_cnt  <= '0;
        end else begin
            act_cnt <= act_dec;
            col_cnt <= col_dec;
            pre_cnt <= pre_dec;
            if (ev_act) begin
                is_open  <= 1'b1;
                open_row <= act_row;
                act_cnt  <= RC_L;
                col_cnt  <= RCD_L;
                pre_cnt  <= RAS_L;
            end
            if (ev_pre) begin
                is_open <= 1'b0;
                act_cnt <= (act_dec > RP_L) ? act_dec : RP_L;
            end
            if (ev_wr) begin
                pre_cnt <= (pre_dec > RDL_L) ? pre_dec : RDL_L;
            end
        end
    end

    assign can_act = (act_cnt == '0);
    assign can_col = (col_cnt == '0);
    assign can_pre = (pre_cnt == '0);

    // R5: a row is opened only in a closed bank, and only after its wait ran out
    a_r5_act_closed_bank: assert property (@(posedge clk) disable iff (rst)
        ev_act |-> (!is_open && can_act));
    // R6: column commands land only on an open row
    a_r6_col_on_open_row: assert property (@(posedge clk) disable iff (rst)
        ev_col |-> is_open);
    // R5: an open row is closed only after its active/write-recovery windows
    a_r5_pre_after_windows: assert property (@(posedge clk) disable iff (rst)
        (ev_pre && is_open) |-> can_pre);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack,
    output logic due
);
    localparam int TW = $clog2(INTERVAL + 1);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= '0;
            due  <= 1'b0;
        end else if (run) begin
            if (tick == LAST) begin
                tick <= '0;
                due  <= 1'b1;
            end else begin
                tick <= tick + 1'b1;
                if (ack) due <= 1'b0;
            end
        end
    end

    // R7: a request is only withdrawn by the refresh that serves it
    a_r7_due_held: assert property (@(posedge clk) disable iff (rst)
        (due && !ack) |=> due);
endmodule

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched
    import sdram_seq_pkg::*;
#(
    parameter int NB        = 4,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int DATA_W    = 32,
    parameter int CAS_LAT   = 3,
    parameter int T_INIT    = 20000,
    parameter int INIT_REFS = 2,
    parameter int T_RP      = 2,
    parameter int T_RC      = 7,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int CW        = 4,
    localparam int ADDR_W   = 2 + ROW_W + COL_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       req_ready,
    input  logic                       ref_due,
    output logic                       ref_ack,
    output logic                       run_phase,
    input  logic [NB-1:0]              bk_open,
    input  logic [NB-1:0][ROW_W-1:0]   bk_row,
    input  logic [NB-1:0]              bk_can_act,
    input  logic [NB-1:0]              bk_can_col,
    input  logic [NB-1:0]              bk_can_pre,
    output logic [NB-1:0]              ev_act,
    output logic [NB-1:0]              ev_pre,
    output logic [NB-1:0]              ev_col,
    output logic [NB-1:0]              ev_wr,
    output sd_cmd_e                    nx_cmd,
    output logic [1:0]                 nx_ba,
    output logic [ROW_W-1:0]           nx_addr,
    output logic [DATA_W-1:0]          nx_wdata,
    output logic                       nx_oe,
    output logic                       nx_rd
);
    localparam int IW = $clog2(T_INIT + 1);
    localparam int RW = $clog2(INIT_REFS + 2);
    localparam logic [CW-1:0] RP_L  = CW'(T_RP - 1);
    localparam logic [CW-1:0] RC_L  = CW'(T_RC - 1);
    localparam logic [CW-1:0] MRD_L = CW'(T_MRD - 1);
    localparam logic [CW-1:0] RRD_L = CW'(T_RRD - 1);
    localparam logic [CW-1:0] CL_L  = CW'(CAS_LAT);

    phase_e          phase;
    logic [IW-1:0]   init_cnt;
    logic [RW-1:0]   refs_left;
    logic [CW-1:0]   gwait, rrd_cnt, turn_cnt;
    logic            nx_all;

    logic [1:0]       rq_bank;
    logic [ROW_W-1:0] rq_row;
    logic [COL_W-1:0] rq_col;
    logic             all_pre_ok, all_act_ok;

    assign rq_bank = req_addr[ADDR_W-1 -: 2];
    assign rq_row  = req_addr[COL_W +: ROW_W];
    assign rq_col  = req_addr[COL_W-1:0];
    assign all_pre_ok = &(~bk_open | bk_can_pre);
    assign all_act_ok = &bk_can_act;
    assign run_phase  = (phase == PH_RUN);
    assign nx_wdata   = req_wdata;

    always_comb begin
        nx_cmd    = CMD_NOP;
        nx_ba     = '0;
        nx_addr   = '0;
        nx_oe     = 1'b0;
        nx_rd     = 1'b0;
        nx_all    = 1'b0;
        ev_act    = '0;
        ev_pre    = '0;
        ev_col    = '0;
        ev_wr     = '0;
        req_ready = 1'b0;
        ref_ack   = 1'b0;
        unique case (phase)
            PH_POWER: begin
                if (init_cnt == '0) begin
                    nx_cmd      = CMD_PRE;
                    nx_addr[10] = 1'b1;
                    nx_all      = 1'b1;
                    ev_pre      = '1;
                end
            end
            PH_INIT_REF: begin
                if (gwait == '0) begin
                    if (refs_left != '0) begin
                        nx_cmd = CMD_REF;
                    end else begin
                        nx_cmd        = CMD_MRS;
                        nx_addr[10:0] = mode_word(CAS_LAT);
                    end
                end
            end
            default: begin
                if (gwait == '0) begin
                    if (ref_due) begin
                        if (|bk_open) begin
                            if (all_pre_ok) begin
                                nx_cmd      = CMD_PRE;
                                nx_addr[10] = 1'b1;
                                nx_all      = 1'b1;
                                ev_pre      = '1;
                            end
                        end else if (all_act_ok) begin
                            nx_cmd  = CMD_REF;
                            ref_ack = 1'b1;
                        end
                    end else if (req_valid) begin
                        nx_ba = rq_bank;
                        if (bk_open[rq_bank] && bk_row[rq_bank] == rq_row) begin
                            if (bk_can_col[rq_bank] && (!req_write || turn_cnt == '0)) begin
                                nx_cmd            = req_write ? CMD_WR : CMD_RD;
                                nx_addr[COL_W-1:0] = rq_col;
                                nx_oe             = req_write;
                                nx_rd             = !req_write;
                                req_ready         = 1'b1;
                                ev_col[rq_bank]   = 1'b1;
                                ev_wr[rq_bank]    = req_write;
                            end
                        end else if (bk_open[rq_bank]) begin
                            if (bk_can_pre[rq_bank]) begin
                                nx_cmd          = CMD_PRE;
                                ev_pre[rq_bank] = 1'b1;
                            end
                        end else if (bk_can_act[rq_bank] && rrd_cnt == '0) begin
                            nx_cmd          = CMD_ACT;
                            nx_addr         = rq_row;
                            ev_act[rq_bank] = 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_POWER;
            init_cnt  <= IW'(T_INIT);
            refs_left <= RW'(INIT_REFS);
            gwait     <= '0;
            rrd_cnt   <= '0;
            turn_cnt  <= '0;
        end else begin
            if (init_cnt != '0) init_cnt <= init_cnt - 1'b1;
            gwait    <= (gwait    != '0) ? gwait    - 1'b1 : '0;
            rrd_cnt  <= (rrd_cnt  != '0) ? rrd_cnt  - 1'b1 : '0;
            turn_cnt <= (turn_cnt != '0) ? turn_cnt - 1'b1 : '0;
            unique case (nx_cmd)
                CMD_PRE: begin
                    if (nx_all) gwait <= RP_L;
                    if (phase == PH_POWER) phase <= PH_INIT_REF;
                end
                CMD_REF: begin
                    gwait <= RC_L;
                    if (phase == PH_INIT_REF) refs_left <= refs_left - 1'b1;
                end
                CMD_MRS: begin
                    gwait <= MRD_L;
                    phase <= PH_RUN;
                end
                CMD_ACT: rrd_cnt  <= RRD_L;
                CMD_RD:  turn_cnt <= CL_L;
                default: ;
            endcase
        end
    end

    // R7: refresh outranks any user request while it is pending
    a_r7_ref_priority: assert property (@(posedge clk) disable iff (rst)
        (ref_due && phase == PH_RUN) |-> !req_ready);
    // R1: nothing is accepted before the device is programmed
    a_r1_no_accept_early: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_RUN) |-> !req_ready);
endmodule

// File: rtl/sdram_sequencer.sv
module sdram_sequencer
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int COL_W        = 8,
    parameter int DATA_W       = 32,
    parameter int CAS_LAT      = 3,
    parameter int T_INIT       = 20000,
    parameter int INIT_REFS    = 2,
    parameter int REF_INTERVAL = 780,
    parameter int T_RP         = 2,
    parameter int T_RCD        = 2,
    parameter int T_RAS        = 5,
    parameter int T_RC         = 7,
    parameter int T_RRD        = 2,
    parameter int T_RDL        = 2,
    parameter int T_MRD        = 2,
    localparam int NB          = 4,
    localparam int ADDR_W      = 2 + ROW_W + COL_W,
    localparam int MW          = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [1:0]        sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [MW-1:0]     sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    localparam int TMAX = max2(max2(max2(T_RC, T_RAS), max2(T_RP, T_RDL)),
                               max2(max2(T_RCD, T_RRD), max2(T_MRD, CAS_LAT + 1)));
    localparam int CW   = $clog2(TMAX + 1) + 1;

    logic [NB-1:0]            bk_open, bk_can_act, bk_can_col, bk_can_pre;
    logic [NB-1:0][ROW_W-1:0] bk_row;
    logic [NB-1:0]            ev_act, ev_pre, ev_col, ev_wr;
    sd_cmd_e                  nx_cmd, cmd_q;
    logic [1:0]               nx_ba;
    logic [ROW_W-1:0]         nx_addr;
    logic [DATA_W-1:0]        nx_wdata;
    logic                     nx_oe, nx_rd;
    logic                     ref_due, ref_ack, run_phase;
    logic [CAS_LAT:0]         rd_pipe;

    sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk(clk), .rst(rst), .run(run_phase), .ack(ref_ack), .due(ref_due)
    );

    sdram_cmd_sched #(
        .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .CAS_LAT(CAS_LAT), .T_INIT(T_INIT), .INIT_REFS(INIT_REFS),
        .T_RP(T_RP), .T_RC(T_RC), .T_RRD(T_RRD), .T_MRD(T_MRD), .CW(CW)
    ) u_sched (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .ref_due(ref_due), .ref_ack(ref_ack), .run_phase(run_phase),
        .bk_open(bk_open), .bk_row(bk_row), .bk_can_act(bk_can_act),
        .bk_can_col(bk_can_col), .bk_can_pre(bk_can_pre),
        .ev_act(ev_act), .ev_pre(ev_pre), .ev_col(ev_col), .ev_wr(ev_wr),
        .nx_cmd(nx_cmd), .nx_ba(nx_ba), .nx_addr(nx_addr),
        .nx_wdata(nx_wdata), .nx_oe(nx_oe), .nx_rd(nx_rd)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdram_bank_track #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
            .T_RP(T_RP), .T_RDL(T_RDL), .CW(CW)
        ) u_track (
            .clk(clk), .rst(rst),
            .ev_act(ev_act[b]), .ev_pre(ev_pre[b]), .ev_col(ev_col[b]),
            .ev_wr(ev_wr[b]), .act_row(nx_addr),
            .is_open(bk_open[b]), .open_row(bk_row[b]),
            .can_act(bk_can_act[b]), .can_col(bk_can_col[b]),
            .can_pre(bk_can_pre[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= CMD_NOP;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
            sd_dqm    <= '1;
            sd_cke    <= 1'b0;
            rd_pipe   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            cmd_q     <= nx_cmd;
            sd_ba     <= nx_ba;
            sd_addr   <= nx_addr;
            sd_dq_out <= nx_oe ? nx_wdata : '0;
            sd_dq_oe  <= nx_oe;
            sd_dqm    <= run_phase ? '0 : '1;
            sd_cke    <= 1'b1;
            rd_pipe   <= {rd_pipe[CAS_LAT-1:0], nx_rd};
            rsp_valid <= rd_pipe[CAS_LAT];
            if (rd_pipe[CAS_LAT]) rsp_data <= sd_dq_in;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

    // R7: refresh only reaches the bus with every bank closed
    a_r7_ref_banks_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_REF) |-> (bk_open == '0));
    // R2: the cycle after a mode register set is idle
    a_r2_mrs_gap: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));
    // R7: the cycle after a refresh is idle
    a_r7_ref_gap: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_REF) |=> (cmd_q == CMD_NOP));
    // R9: the data bus is driven only with a write command
    a_r9_oe_only_write: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (cmd_q == CMD_WR));
    // R10: column commands go out unmasked
    a_r10_col_unmasked: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (sd_dqm == '0));
    // R8: responses are single-cycle pulses for back-to-back-free reads
    a_r8_rsp_from_pipe: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd_pipe[CAS_LAT]));
endmodule

// File: tb/sdram_sequencer_test.sv
module sdram_sequencer_test;
    localparam int ROW_W = 12, COL_W = 8, DATA_W = 32, CL = 3;
    localparam int T_INIT = 20, INIT_REFS = 2, REF_INT = 300;
    localparam int T_RP = 2, T_RCD = 2, T_RAS = 5, T_RC = 7, T_RRD = 2, T_RDL = 2, T_MRD = 2;
    localparam int ADDR_W = 2 + ROW_W + COL_W;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0, rsp_data, sd_dq_out;
    logic [DATA_W-1:0] sd_dq_in;
    logic rsp_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0] sd_ba;
    logic [ROW_W-1:0] sd_addr;
    logic [3:0] sd_dqm;

    sdram_sequencer #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CL),
        .T_INIT(T_INIT), .INIT_REFS(INIT_REFS), .REF_INTERVAL(REF_INT),
        .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
        .T_RRD(T_RRD), .T_RDL(T_RDL), .T_MRD(T_MRD)
    ) uut (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---------------- bus monitor ----------------
    int last_act[4], last_pre[4], last_wr[4];
    int last_rd = -1000, last_act_any = -1000, last_ref = -1000, last_mrs = -1000, last_pre_all = -1000;
    bit mopen[4];
    logic [ROW_W-1:0] mrow[4];
    int init_stage = 0, n_act = 0, n_pre = 0, n_ref = 0, run_ref_gap_start = -1, nops_before = 0;
    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    initial for (int i = 0; i < 4; i++) begin
        last_act[i] = -1000; last_pre[i] = -1000; last_wr[i] = -1000; mopen[i] = 0;
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (!rst) begin
        logic [1:0] b;
        b = sd_ba;
        if (init_stage <= INIT_REFS + 1) chk(sd_dqm == 4'hF, "R10 dqm before mode", sd_dqm, 4'hF);
        if (cmd != 4'b0111 && cmd != 4'b0100) chk(!sd_dq_oe, "R9 oe only on write", sd_dq_oe, 0);
        if (cmd == 4'b0111 && init_stage == 0) nops_before++;
        if (cmd != 4'b0111) begin
            // R1 / R2 start-up order
            if (init_stage == 0) begin
                chk(cmd == 4'b0010 && sd_addr[10], "R1 first cmd precharge-all", {cmd, sd_addr[10]}, 5'b00101);
                chk(nops_before >= T_INIT && sd_cke, "R1 power-up wait", nops_before, T_INIT);
                init_stage = 1;
            end else if (init_stage <= INIT_REFS) begin
                chk(cmd == 4'b0001, "R1 init refresh", cmd, 4'b0001);
                init_stage++;
            end else if (init_stage == INIT_REFS + 1) begin
                chk(cmd == 4'b0000, "R1 mode set after refreshes", cmd, 4'b0000);
                chk(sd_addr[10:0] == 11'h230 && sd_ba == 2'b00, "R2 mode value", {sd_ba, sd_addr[10:0]}, 13'h0230);
                init_stage++;
                run_ref_gap_start = cyc;
            end
            chk(cyc - last_mrs >= T_MRD, "R2 gap after mode set", cyc - last_mrs, T_MRD);
            chk(cyc - last_ref >= T_RC, "R7 gap after refresh", cyc - last_ref, T_RC);
            case (cmd)
                4'b0011: begin
                    chk(!mopen[b], "R6 act on closed bank", mopen[b], 0);
                    chk(cyc - last_pre[b] >= T_RP, "R5 precharge to act", cyc - last_pre[b], T_RP);
                    chk(cyc - last_act[b] >= T_RC, "R4 act to act same bank", cyc - last_act[b], T_RC);
                    chk(cyc - last_act_any >= T_RRD, "R4 act to act any bank", cyc - last_act_any, T_RRD);
                    mopen[b] = 1; mrow[b] = sd_addr; last_act[b] = cyc; last_act_any = cyc; n_act++;
                end
                4'b0101, 4'b0100: begin
                    chk(mopen[b], "R6 column on open row", mopen[b], 1);
                    chk(!sd_addr[10], "R6 A10 low on column", sd_addr[10], 0);
                    chk(cyc - last_act[b] >= T_RCD, "R4 act to column", cyc - last_act[b], T_RCD);
                    chk(sd_dqm == 0, "R10 dqm zero on column", sd_dqm, 0);
                    if (cmd == 4'b0100) begin
                        chk(sd_dq_oe, "R9 oe with write", sd_dq_oe, 1);
                        chk(cyc - last_rd > CL, "R9 read to write turnaround", cyc - last_rd, CL + 1);
                        last_wr[b] = cyc;
                    end else last_rd = cyc;
                end
                4'b0010: begin
                    n_pre++;
                    for (int i = 0; i < 4; i++) if (sd_addr[10] || i == b) begin
                        if (mopen[i]) begin
                            chk(cyc - last_act[i] >= T_RAS, "R5 act to precharge", cyc - last_act[i], T_RAS);
                            chk(cyc - last_wr[i] >= T_RDL, "R5 write to precharge", cyc - last_wr[i], T_RDL);
                        end
                        mopen[i] = 0; last_pre[i] = cyc;
                    end
                    if (sd_addr[10]) last_pre_all = cyc;
                end
                4'b0001: begin
                    chk(!(mopen[0] | mopen[1] | mopen[2] | mopen[3]), "R7 refresh with banks closed",
                        {mopen[3], mopen[2], mopen[1], mopen[0]}, 0);
                    for (int i = 0; i < 4; i++)
                        chk(cyc - last_pre[i] >= T_RP, "R7 precharge to refresh", cyc - last_pre[i], T_RP);
                    if (init_stage > INIT_REFS + 1) begin
                        chk(cyc - run_ref_gap_start <= REF_INT + 30, "R7 refresh interval",
                            cyc - run_ref_gap_start, REF_INT);
                        run_ref_gap_start = cyc; n_ref++;
                    end
                    last_ref = cyc;
                end
                4'b0000: last_mrs = cyc;
                default: chk(0, "R3 unknown command", cmd, 4'b0111);
            endcase
        end
    end

    // ---------------- memory model behind the bus ----------------
    logic [DATA_W-1:0] model_mem[128];
    logic [DATA_W-1:0] dpipe[CL];
    initial for (int i = 0; i < 128; i++) model_mem[i] = 32'hC0DE_0000 + i;
    assign sd_dq_in = dpipe[CL-1];

    always @(posedge clk) begin
        logic [6:0] ix;
        ix = {sd_ba, mrow[sd_ba][1:0], sd_addr[2:0]};
        dpipe[0] <= (!rst && cmd == 4'b0101) ? model_mem[ix] : 32'hDEAD_BEEF;
        for (int i = 1; i < CL; i++) dpipe[i] <= dpipe[i-1];
        if (!rst && cmd == 4'b0100 && sd_dq_oe) model_mem[ix] <= sd_dq_out;
    end

    // ---------------- reference and response checking ----------------
    logic [DATA_W-1:0] ref_mem[128];
    logic [DATA_W-1:0] exp_q[$];
    initial for (int i = 0; i < 128; i++) ref_mem[i] = 32'hC0DE_0000 + i;

    always @(negedge clk) if (!rst && rsp_valid) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected response", rsp_data, 0);
        else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            chk(rsp_data == e, "R8 read data", rsp_data, e);
        end
    end

    function automatic logic [ADDR_W-1:0] mk_addr(input int bk, input int row, input int col);
        return {2'(bk), ROW_W'(row), COL_W'(col)};
    endfunction

    task automatic do_req(input bit wr, input int bk, input int row, input int col, input logic [31:0] d);
        int ix;
        ix = bk * 32 + (row % 4) * 8 + (col % 8);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = mk_addr(bk, row, col); req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        if (wr) ref_mem[ix] = d; else exp_q.push_back(ref_mem[ix]);
        @(negedge clk);
        // R11: accepted request is the next bus command
        chk(cmd == (wr ? 4'b0100 : 4'b0101) && sd_ba == 2'(bk) && sd_addr[COL_W-1:0] == COL_W'(col),
            "R11 accepted request on bus", {cmd, sd_ba, sd_addr[7:0]}, {(wr ? 4'b0100 : 4'b0101), 2'(bk), 8'(col)});
        req_valid = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > 150000);
        chk(0, "watchdog expired", cyc, 150000);
        finish_run();
    end

    initial begin
        int a0, p0, refs;
        void'($urandom(32'h5D2A_11C7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd == 4'b0111 && sd_dqm == 4'hF && !req_ready && !rsp_valid, "R1 reset state",
            {cmd, sd_dqm, req_ready, rsp_valid}, {4'b0111, 4'hF, 2'b00});
        rst = 0;
        // R1: a request presented early is not taken until start-up ends
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = mk_addr(0, 0, 0); req_wdata = 32'h1;
        while (init_stage <= INIT_REFS + 1) begin
            #1; chk(!req_ready, "R1 no accept before mode set", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 0;
        // directed cases right after a refresh
        refs = n_ref;
        wait (n_ref > refs);
        do_req(1, 0, 1, 0, 32'hA5A5_0001);
        a0 = n_act; p0 = n_pre;
        do_req(0, 0, 1, 0, 0);
        chk(n_act == a0 && n_pre == p0, "R6 row hit no act/pre", n_act - a0 + n_pre - p0, 0);
        a0 = n_act; p0 = n_pre;
        do_req(0, 0, 2, 3, 0);
        chk(n_act == a0 + 1 && n_pre == p0 + 1, "R6 row miss one pre one act",
            {n_pre - p0, n_act - a0}, {32'd1, 32'd1});
        do_req(1, 3, 0, 7, 32'hFFFF_0003);
        do_req(0, 3, 0, 7, 0);
        do_req(1, 3, 0, 6, 32'h1234_5678);
        do_req(0, 3, 0, 6, 0);
        // random traffic
        for (int n = 0; n < 400; n++)
            do_req($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
                   $urandom_range(0, 7), $urandom);
        repeat (CL + 6) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all reads answered", exp_q.size(), 0);
        chk(n_ref >= 3, "R7 refreshes during traffic", n_ref, 3);
        finish_run();
    end
endmodule